// File: doc/BRIEF.md
# Floppy Controller Lockable Configuration Registers

This block keeps the configuration state that a floppy disk controller's command processor needs. That state is the FIFO enable, the FIFO threshold, the track where write precompensation starts, a lock flag, and the perpendicular recording controls. The perpendicular controls are a write-gate bit, a gap bit and four per-drive bits. A command parser placed upstream hands the block one decoded command per accepted cycle, with up to two argument bytes. The block applies configure, lock and perpendicular commands to its registers. For lock and register-dump commands it returns result bytes through a valid/ready byte port.

The block treats the two reset kinds differently. The chip-level hardware reset restores every default. A software reset, which comes from the operator or data-rate register path, restores the three FIFO and precompensation parameters only while the lock flag is clear. It always drops the perpendicular gap and write-gate selection, and it abandons any result bytes not yet read.

The block also decodes the write-gate and gap pair into the gap-2 length and the part of that gap the write-data operation writes, both for use by the formatter. It merges per-drive force bits into the disk-change indication of the currently selected drive.

Top module: `fdc_cfg_regs`

## Requirements
- R1: After hardware reset (`rst_n` low at a clock edge) the outputs are: `cfg_efifo`=1, `cfg_fifothr`=0, `cfg_pretrk`=0, `cfg_lock`=0, `perp_wgate`=0, `perp_gap`=0, `perp_drv`=0, `res_valid`=0 and `cmd_ready`=1.
- R2: A configure command (`cmd_op`=0) sets `cfg_efifo` from `cmd_arg0[4]`, `cfg_fifothr` from `cmd_arg0[3:0]` and `cfg_pretrk` from `cmd_arg1`. It produces no result byte.
- R3: A lock command (`cmd_op`=1) sets `cfg_lock` from `cmd_arg0[0]`. It then returns exactly one result byte, which carries the new lock value in bit 4 and zeros in every other bit.
- R4: A software reset while `cfg_lock`=1 leaves `cfg_efifo`, `cfg_fifothr` and `cfg_pretrk` unchanged.
- R5: A software reset while `cfg_lock`=0 returns `cfg_efifo`, `cfg_fifothr` and `cfg_pretrk` to 1, 0 and 0.
- R6: Any software reset clears `perp_wgate` and `perp_gap`, keeps `perp_drv` and `cfg_lock`, and drops pending result bytes (`res_valid`=0). A command offered in the same cycle is ignored.
- R7: A perpendicular command (`cmd_op`=2) sets `perp_wgate` from `cmd_arg0[0]` and `perp_gap` from `cmd_arg0[1]`. It loads `perp_drv` from `cmd_arg0[5:2]` only when `cmd_arg0[7]`=1. It produces no result byte.
- R8: A dump command (`cmd_op`=3) returns eight bytes in this order: byte 0 = {000, efifo, fifothr[3:0]}, byte 1 = pretrk, bytes 2 to 6 = 0, byte 7 = {lock, 0, perp_drv[3:0], gap, wgate}.
- R9: The pair {wgate, gap} sets (`gap2_len`, `gap2_wr`) as follows: 00 gives (22, 0), 01 gives (22, 19), 10 gives (22, 0) and 11 gives (41, 38).
- R10: While `res_valid`=1 and `res_ready`=0, `res_data` stays stable. Each cycle with both signals high consumes one byte. `cmd_ready` is 0 while result bytes are pending, and commands offered then are ignored.
- R11: `dskchg_out` is 1 when `dskchg_in` is 1, or when `force_chg[drive_sel]` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| soft_rst | input | 1 | Software reset from the operator or data-rate register path |
| cmd_valid | input | 1 | Decoded command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 configure, 1 lock, 2 perpendicular, 3 dump |
| cmd_arg0 | input | 8 | First argument byte |
| cmd_arg1 | input | 8 | Second argument byte (precompensation track) |
| res_valid | output | 1 | Result byte available |
| res_ready | input | 1 | Consumer takes the result byte |
| res_data | output | 8 | Result byte |
| cfg_efifo | output | 1 | FIFO enable bit (1 means FIFO disabled) |
| cfg_fifothr | output | 4 | FIFO threshold |
| cfg_pretrk | output | 8 | Precompensation start track |
| cfg_lock | output | 1 | Lock flag |
| perp_wgate | output | 1 | Perpendicular write-gate bit |
| perp_gap | output | 1 | Perpendicular gap bit |
| perp_drv | output | 4 | Per-drive perpendicular bits |
| gap2_len | output | 6 | Gap-2 length in bytes |
| gap2_wr | output | 6 | Bytes of gap 2 written by the write-data operation |
| drive_sel | input | 1 | Selected drive |
| force_chg | input | 2 | Per-drive force-disk-change bits |
| dskchg_in | input | 1 | Disk-change indication from the selected drive |
| dskchg_out | output | 1 | Merged disk-change indication |

## Verification
The configure sweep covers every threshold with both FIFO-enable values, using track values that differ each time, so a swapped or dropped argument field shows up. All four write-gate/gap pairs are applied with and without the drive-update bit. This separates the reserved pair from both perpendicular rates, and it shows the drive bits being loaded or kept. Software resets are issued with the lock flag clear and with it set, after non-default settings, so the protected fields, the always-cleared fields and the preserved drive bits are told apart. The disk-change merge is swept over all sixteen combinations of force bits, selected drive and raw input.

// File: rtl/fdc_cfg_pkg.sv
// Shared widths, command codes and the configuration record for the
// floppy controller configuration registers.
package fdc_cfg_pkg;
    localparam int THR_W      = 4;   // FIFO threshold width
    localparam int TRK_W      = 8;   // precompensation track width
    localparam int NPERP      = 4;   // per-drive perpendicular bits
    localparam int DUMP_BYTES = 8;   // bytes returned by a dump command

    typedef enum logic [1:0] {
        OP_CONFIGURE = 2'd0,
        OP_LOCK      = 2'd1,
        OP_PERP      = 2'd2,
        OP_DUMPREG   = 2'd3
    } fdc_op_e;

    typedef struct packed {
        logic             efifo;
        logic [THR_W-1:0] fifothr;
        logic [TRK_W-1:0] pretrk;
    } fdc_cfg_t;

    localparam fdc_cfg_t CFG_DEFAULT = '{efifo: 1'b1, fifothr: '0, pretrk: '0};
endpackage

// File: rtl/fdc_cfg_store.sv
// Configuration store: holds the lockable FIFO/precompensation record,
// the lock flag and the perpendicular settings.
// Assumes cmd_fire is already qualified (no soft reset, block ready).
// Hardware reset restores everything; soft reset restores the record
// only when unlocked and always clears write-gate and gap.
module fdc_cfg_store
    import fdc_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cmd_fire,
    input  fdc_op_e          cmd_op,
    input  logic [7:0]       arg0,
    input  logic [7:0]       arg1,
    output fdc_cfg_t         cfg,
    output logic             lock,
    output logic             wgate,
    output logic             gap,
    output logic [NPERP-1:0] perp_drv
);
    fdc_cfg_t         cfg_q;
    logic             lock_q;
    logic             wgate_q;
    logic             gap_q;
    logic [NPERP-1:0] drv_q;
    logic             unused_arg;

    assign unused_arg = arg0[6];

    // Lockable record and lock flag: reset kinds, then configure/lock commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_DEFAULT;
            lock_q <= 1'b0;
        end else if (soft_rst) begin
            if (!lock_q) begin
                cfg_q <= CFG_DEFAULT;
            end
        end else if (cmd_fire) begin
            if (cmd_op == OP_CONFIGURE) begin
                cfg_q.efifo   <= arg0[THR_W];
                cfg_q.fifothr <= arg0[THR_W-1:0];
                cfg_q.pretrk  <= arg1[TRK_W-1:0];
            end
            if (cmd_op == OP_LOCK) begin
                lock_q <= arg0[0];
            end
        end
    end

    // Perpendicular settings: soft reset clears the mode pair, command rewrites it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wgate_q <= 1'b0;
            gap_q   <= 1'b0;
            drv_q   <= '0;
        end else if (soft_rst) begin
            wgate_q <= 1'b0;
            gap_q   <= 1'b0;
        end else if (cmd_fire && cmd_op == OP_PERP) begin
            wgate_q <= arg0[0];
            gap_q   <= arg0[1];
            if (arg0[7]) begin
                drv_q <= arg0[2 +: NPERP];
            end
        end
    end

    assign cfg      = cfg_q;
    assign lock     = lock_q;
    assign wgate    = wgate_q;
    assign gap      = gap_q;
    assign perp_drv = drv_q;

    AST_LOCK_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && lock_q) |=> $stable(cfg_q)); // R4
    AST_UNLOCKED_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !lock_q) |=> (cfg_q == CFG_DEFAULT)); // R5
    AST_SOFT_CLEARS_PERP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!wgate_q && !gap_q && $stable(drv_q) && $stable(lock_q))); // R6
    AST_LOCK_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_LOCK) |=> (lock_q == $past(arg0[0]))); // R3
endmodule

// File: rtl/fdc_perp_decode.sv
// Gap decoder: maps the write-gate/gap pair to the gap-2 length and the
// part of it written by a write-data operation. Purely combinational;
// clk/rst_n only sample the checks. The reserved pair acts as conventional.
module fdc_perp_decode #(
    parameter int GAP_W    = 6,
    parameter int LEN_STD  = 22,
    parameter int LEN_1M   = 41,
    parameter int WR_500K  = 19,
    parameter int WR_1M    = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wgate,
    input  logic             gap,
    output logic [GAP_W-1:0] gap2_len,
    output logic [GAP_W-1:0] gap2_wr
);
    // Table lookup on the encoded mode pair.
    always_comb begin
        unique case ({wgate, gap})
            2'b01: begin
                gap2_len = GAP_W'(LEN_STD);
                gap2_wr  = GAP_W'(WR_500K);
            end
            2'b11: begin
                gap2_len = GAP_W'(LEN_1M);
                gap2_wr  = GAP_W'(WR_1M);
            end
            default: begin
                gap2_len = GAP_W'(LEN_STD);
                gap2_wr  = '0;
            end
        endcase
    end

    AST_GAP_WR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        gap2_wr < gap2_len); // R9
    AST_CONVENTIONAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !gap |-> (gap2_wr == '0)); // R9
endmodule

// File: rtl/fdc_result_seq.sv
// Result sequencer: after a lock or dump command presents its result bytes
// one at a time on a valid/ready port. Assumes the sourced registers are
// stable while busy (the top refuses commands then). Soft reset abandons.
module fdc_result_seq
    import fdc_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cmd_fire,
    input  fdc_op_e          cmd_op,
    input  fdc_cfg_t         cfg,
    input  logic             lock,
    input  logic             wgate,
    input  logic             gap,
    input  logic [NPERP-1:0] perp_drv,
    input  logic             res_ready,
    output logic             busy,
    output logic [7:0]       res_data
);
    localparam int IDX_W = $clog2(DUMP_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DUMP_BYTES - 1);

    logic             busy_q;
    logic             dump_q;
    logic [IDX_W-1:0] idx_q;

    // Byte counter: start on a result-bearing command, step on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dump_q <= 1'b0;
            idx_q  <= '0;
        end else if (soft_rst) begin
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (cmd_fire && (cmd_op == OP_LOCK || cmd_op == OP_DUMPREG)) begin
                busy_q <= 1'b1;
                dump_q <= (cmd_op == OP_DUMPREG);
                idx_q  <= '0;
            end
        end else if (res_ready) begin
            if (!dump_q || idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Result byte mux: lock status byte or the indexed dump byte.
    always_comb begin
        res_data = '0;
        if (!dump_q) begin
            res_data[4] = lock;
        end else begin
            case (idx_q)
                IDX_W'(0): res_data[THR_W:0] = {cfg.efifo, cfg.fifothr};
                IDX_W'(1): res_data[TRK_W-1:0] = cfg.pretrk;
                LAST_IDX: begin
                    res_data[7]          = lock;
                    res_data[2 +: NPERP] = perp_drv;
                    res_data[1]          = gap;
                    res_data[0]          = wgate;
                end
                default: res_data = '0;
            endcase
        end
    end

    assign busy = busy_q;

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !res_ready && !soft_rst) |=> (busy_q && $stable(res_data))); // R10
    AST_LOCK_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !dump_q && res_ready) |=> !busy_q); // R3
    AST_SOFT_DROPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy_q); // R6
endmodule

// File: rtl/fdc_dskchg.sv
// Disk-change merge: a per-drive force bit makes the disk-change signal
// read active while its drive is selected. Combinational; clk/rst_n feed
// the check only.
module fdc_dskchg #(
    parameter int NDRV  = 2,
    parameter int SEL_W = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NDRV-1:0]  force_chg,
    input  logic [SEL_W-1:0] drive_sel,
    input  logic             dskchg_in,
    output logic             dskchg_out
);
    logic [NDRV-1:0] hit;

    // One comparator per drive: forced and currently selected.
    for (genvar d = 0; d < NDRV; d++) begin : g_drv
        assign hit[d] = force_chg[d] && (drive_sel == SEL_W'(d));
    end

    assign dskchg_out = dskchg_in | (|hit);

    AST_FORCE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        force_chg[drive_sel] |-> dskchg_out); // R11
    AST_NO_SPURIOUS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        (!dskchg_in && !force_chg[drive_sel]) |-> !dskchg_out); // R11
endmodule

// File: rtl/fdc_cfg_regs.sv
// Top of the floppy controller configuration registers. Qualifies
// incoming commands (refused while results pend or during soft reset),
// and ties together store, gap decoder, result sequencer and disk-change merge.
module fdc_cfg_regs
    import fdc_cfg_pkg::*;
#(
    parameter int NDRV  = 2,
    parameter int GAP_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_arg0,
    input  logic [7:0]  cmd_arg1,
    output logic        res_valid,
    input  logic        res_ready,
    output logic [7:0]  res_data,
    output logic        cfg_efifo,
    output logic [3:0]  cfg_fifothr,
    output logic [7:0]  cfg_pretrk,
    output logic        cfg_lock,
    output logic        perp_wgate,
    output logic        perp_gap,
    output logic [3:0]  perp_drv,
    output logic [5:0]  gap2_len,
    output logic [5:0]  gap2_wr,
    input  logic [0:0]  drive_sel,
    input  logic [1:0]  force_chg,
    input  logic        dskchg_in,
    output logic        dskchg_out
);
    fdc_op_e          op;
    fdc_cfg_t         cfg;
    logic             lock;
    logic             wgate;
    logic             gap;
    logic [NPERP-1:0] drv;
    logic             busy;
    logic             cmd_fire;

    assign op        = fdc_op_e'(cmd_op);
    assign cmd_ready = !busy;
    assign cmd_fire  = cmd_valid && !busy && !soft_rst;

    fdc_cfg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .cmd_fire (cmd_fire),
        .cmd_op   (op),
        .arg0     (cmd_arg0),
        .arg1     (cmd_arg1),
        .cfg      (cfg),
        .lock     (lock),
        .wgate    (wgate),
        .gap      (gap),
        .perp_drv (drv)
    );

    fdc_perp_decode #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wgate    (wgate),
        .gap      (gap),
        .gap2_len (gap2_len),
        .gap2_wr  (gap2_wr)
    );

    fdc_result_seq u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cmd_fire  (cmd_fire),
        .cmd_op    (op),
        .cfg       (cfg),
        .lock      (lock),
        .wgate     (wgate),
        .gap       (gap),
        .perp_drv  (drv),
        .res_ready (res_ready),
        .busy      (busy),
        .res_data  (res_data)
    );

    fdc_dskchg #(.NDRV(NDRV)) u_chg (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_chg  (force_chg),
        .drive_sel  (drive_sel),
        .dskchg_in  (dskchg_in),
        .dskchg_out (dskchg_out)
    );

    assign res_valid   = busy;
    assign cfg_efifo   = cfg.efifo;
    assign cfg_fifothr = cfg.fifothr;
    assign cfg_pretrk  = cfg.pretrk;
    assign cfg_lock    = lock;
    assign perp_wgate  = wgate;
    assign perp_gap    = gap;
    assign perp_drv    = drv;

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && !soft_rst && !res_ready) |=> busy); // R10
endmodule

// File: tb/fdc_cfg_regs_test.sv
module fdc_cfg_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_arg0 = 8'd0;
    logic [7:0] cmd_arg1 = 8'd0;
    logic       res_valid;
    logic       res_ready = 1'b0;
    logic [7:0] res_data;
    logic       cfg_efifo;
    logic [3:0] cfg_fifothr;
    logic [7:0] cfg_pretrk;
    logic       cfg_lock;
    logic       perp_wgate;
    logic       perp_gap;
    logic [3:0] perp_drv;
    logic [5:0] gap2_len;
    logic [5:0] gap2_wr;
    logic [0:0] drive_sel = 1'b0;
    logic [1:0] force_chg = 2'b00;
    logic       dskchg_in = 1'b0;
    logic       dskchg_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // Reference model state
    int m_efifo, m_thr, m_trk, m_lock, m_wg, m_gp, m_drv;

    always #2 clk = ~clk;

    fdc_cfg_regs uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_defaults();
        m_efifo = 1; m_thr = 0; m_trk = 0;
    endtask

    task automatic send(input int op, input int a0, input int a1);
        @(negedge clk);
        cmd_op = op[1:0]; cmd_arg0 = a0[7:0]; cmd_arg1 = a1[7:0]; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    // Takes one result byte; called at a negedge with res_valid expected high.
    task automatic take(input string req, input int exp);
        chk({req, " valid"}, int'(res_valid), 1);
        chk({req, " data"}, int'(res_data), exp);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    function automatic int dump_byte(input int i);
        case (i)
            0: return (m_efifo << 4) | m_thr;
            1: return m_trk;
            7: return (m_lock << 7) | (m_drv << 2) | (m_gp << 1) | m_wg;
            default: return 0;
        endcase
    endfunction

    task automatic check_cfg(input string req);
        chk({req, " efifo"}, int'(cfg_efifo), m_efifo);
        chk({req, " fifothr"}, int'(cfg_fifothr), m_thr);
        chk({req, " pretrk"}, int'(cfg_pretrk), m_trk);
    endtask

    task automatic do_dump(input string req);
        send(3, 0, 0);
        for (int i = 0; i < 8; i++) take(req, dump_byte(i));
        chk({req, " end of dump"}, int'(res_valid), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        model_defaults();
        m_lock = 0; m_wg = 0; m_gp = 0; m_drv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_cfg("R1");
        chk("R1 lock", int'(cfg_lock), 0);
        chk("R1 wgate", int'(perp_wgate), 0);
        chk("R1 gap", int'(perp_gap), 0);
        chk("R1 drv", int'(perp_drv), 0);
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 cmd_ready", int'(cmd_ready), 1);

        // R2 configure sweep
        for (int e = 0; e < 2; e++) begin
            for (int t = 0; t < 16; t++) begin
                m_efifo = e; m_thr = t; m_trk = (t * 17 + e * 5 + 3) & 255;
                send(0, (e << 4) | t | 8'hE0, m_trk);
                check_cfg("R2");
                chk("R2 no result", int'(res_valid), 0);
            end
        end
        do_dump("R8 after configure");

        // R7/R9/R8 perpendicular sweep
        for (int mode = 0; mode < 4; mode++) begin
            for (int ow = 0; ow < 2; ow++) begin
                int d;
                int elen;
                int ewr;
                d = (mode * 5 + ow * 3 + 1) & 15;
                m_wg = mode >> 1; m_gp = mode & 1;
                if (ow == 1) m_drv = d;
                send(2, (ow << 7) | (d << 2) | (m_gp << 1) | m_wg, 0);
                chk("R7 wgate", int'(perp_wgate), m_wg);
                chk("R7 gap", int'(perp_gap), m_gp);
                chk("R7 drv", int'(perp_drv), m_drv);
                chk("R7 no result", int'(res_valid), 0);
                elen = (mode == 3) ? 41 : 22;
                ewr  = (mode == 1) ? 19 : (mode == 3) ? 38 : 0;
                chk("R9 gap2_len", int'(gap2_len), elen);
                chk("R9 gap2_wr", int'(gap2_wr), ewr);
                do_dump("R8 perp");
            end
        end

        // R3 lock 0, then R5/R6 unlocked software reset
        m_lock = 0;
        send(1, 8'hFE, 0);
        take("R3 lock0 byte", 0);
        chk("R3 single byte", int'(res_valid), 0);
        m_efifo = 0; m_thr = 9; m_trk = 77;
        send(0, 9, 77);
        m_wg = 1; m_gp = 1; m_drv = 10;
        send(2, 8'h80 | (10 << 2) | 3, 0);
        pulse_soft();
        model_defaults(); m_wg = 0; m_gp = 0;
        check_cfg("R5");
        chk("R6 wgate", int'(perp_wgate), 0);
        chk("R6 gap", int'(perp_gap), 0);
        chk("R6 drv kept", int'(perp_drv), m_drv);
        chk("R6 lock kept", int'(cfg_lock), 0);

        // R3 lock 1, then R4/R6 locked software reset
        m_lock = 1;
        send(1, 8'h01, 0);
        take("R3 lock1 byte", 16);
        chk("R3 single byte", int'(res_valid), 0);
        chk("R3 lock out", int'(cfg_lock), 1);
        m_efifo = 0; m_thr = 6; m_trk = 200;
        send(0, 6, 200);
        m_wg = 1; m_gp = 1;
        send(2, 3, 0);
        pulse_soft();
        m_wg = 0; m_gp = 0;
        check_cfg("R4");
        chk("R6 locked wgate", int'(perp_wgate), 0);
        chk("R6 locked gap", int'(perp_gap), 0);
        chk("R6 locked lock", int'(cfg_lock), 1);
        do_dump("R8 locked");

        // R10 handshake hold, refusal while busy
        send(3, 0, 0);
        for (int k = 0; k < 5; k++) begin
            chk("R10 hold valid", int'(res_valid), 1);
            chk("R10 hold data", int'(res_data), dump_byte(0));
            chk("R10 cmd_ready low", int'(cmd_ready), 0);
            @(negedge clk);
        end
        send(0, 8'h1F, 8'h55);
        for (int i = 0; i < 8; i++) take("R10 dump", dump_byte(i));
        check_cfg("R10 refused configure");

        // R6 soft reset abandons a dump in progress
        send(3, 0, 0);
        take("R6 partial", dump_byte(0));
        @(negedge clk);
        soft_rst = 1'b1;
        cmd_op = 2'd0; cmd_arg0 = 8'h1F; cmd_arg1 = 8'h44; cmd_valid = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; cmd_valid = 1'b0;
        chk("R6 res dropped", int'(res_valid), 0);
        chk("R6 cmd_ready", int'(cmd_ready), 1);
        check_cfg("R6 same-cycle cmd ignored");

        // R1 hardware reset while locked
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_defaults(); m_lock = 0; m_drv = 0;
        check_cfg("R1 hw");
        chk("R1 hw lock", int'(cfg_lock), 0);
        chk("R1 hw drv", int'(perp_drv), 0);

        // R11 disk-change sweep
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            force_chg = v[1:0]; drive_sel = v[2]; dskchg_in = v[3];
            #1;
            chk("R11 dskchg", int'(dskchg_out), int'(v[3] | ((v[1:0] >> v[2]) & 1)));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule